// File: doc/BRIEF.md
# Low-Power Mode Controller

This controller moves a device between a fully powered, fully clocked RUN state and a static SLEEP state in which the clock is stopped and most of the chip is switched off. Software raises a sleep request and supplies three settings with it: a RAM retention level, a set of oscillators to keep alive, and whether the periodic wake timer is armed. These settings are captured with the request. The controller then stops the clocks, isolates the domain outputs and opens the power switches. It waits for each switch to acknowledge before it takes the next step.

The controller leaves SLEEP on any enabled wake pin out of a 32-pin vector, on expiry of the periodic timer, or on reset. The exit steps run in the opposite order. The logic domain is powered up and held in reset, isolation is released, the clocks restart with the reset still held, and the reset is released last. On exit the system clock select is forced onto the fast internal RC oscillator. A wake pin seen while entry is still at the clock-gating or isolation step cancels entry. No domain is switched off in that case. The cause of the last wake is kept for software to read.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the controller is in RUN with `run_mode`=1, `clk_en`=1, `pwr_en`=1, `iso_en`=0, `dom_rst`=0, `ram_pwr`=111, `osc_en`=1111, `irc_sel`=1 and `cause_kind`=0 (reset).
- R2: A request accepted in RUN drops `clk_en` on the next cycle. `iso_en` rises one cycle later, and `pwr_en` drops one cycle after that. `sleep_mode` rises only once `pwr_ack` is low and `ram_ack` equals the retention mask.
- R3: During the power-down step and in SLEEP, `ram_pwr` carries the retention mask. Level 1 gives 001, level 2 gives 011 and level 3 gives 111. Level 0 is treated as level 1. In every other state `ram_pwr` is 111.
- R4: During the power-down step and in SLEEP, `osc_en` equals the captured keep mask. Bit 0 is the fast RC, bit 1 the main crystal, bit 2 the slow RC and bit 3 the low-frequency crystal. Bit 2 is forced on when the timer is armed. In every other state `osc_en` is 1111.
- R5: In SLEEP, a pin wakes the device only if its `wake_pins` bit and its `wake_mask` bit are both 1. A pin whose mask bit is 0 leaves the device in SLEEP.
- R6: When armed with reload value N, the timer ends SLEEP on the (N+1)-th `tick_slow` pulse counted while in SLEEP.
- R7: On exit, the cycle after the wake event has `pwr_en`=1, `iso_en`=1, `dom_rst`=1 and `clk_en`=0. Once both acknowledges are high, one cycle follows with `iso_en`=0, `clk_en`=1 and `dom_rst`=1. RUN is then entered with `dom_rst`=0.
- R8: An enabled wake pin during the clock-gating or isolation step returns the controller to RUN on the next cycle, and `pwr_en` never goes low.
- R9: `cause_kind` records the last wake: 0 reset, 1 pin, 2 timer. For a pin wake, `cause_pin` holds the lowest index that is both active and enabled. Pins take priority over the timer.
- R10: `irc_sel` is set on every sleep exit and cleared by a `clk_release` pulse in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Sleep request pulse |
| ret_lvl | input | 2 | Retention level, captured with the request |
| osc_keep | input | 4 | Oscillators kept alive in SLEEP |
| tmr_en | input | 1 | Arms the periodic wake timer |
| tmr_reload | input | 16 | Timer reload value |
| tick_slow | input | 1 | Slow RC clock enable pulse |
| wake_pins | input | 32 | Wake pin levels, already synchronised |
| wake_mask | input | 32 | Per-pin wake enable |
| clk_release | input | 1 | Software gives up the fast RC clock select |
| pwr_ack | input | 1 | Logic-domain power switch acknowledge |
| ram_ack | input | 3 | RAM bank power switch acknowledges |
| clk_en | output | 1 | Clock gate enable for the device |
| iso_en | output | 1 | Domain output isolation |
| pwr_en | output | 1 | Logic-domain power switch enable |
| ram_pwr | output | 3 | RAM bank power switch enables |
| dom_rst | output | 1 | Reset to the switched domains |
| osc_en | output | 4 | Oscillator enables |
| irc_sel | output | 1 | System clock taken from the fast RC |
| run_mode | output | 1 | Controller is in RUN |
| sleep_mode | output | 1 | Controller is in SLEEP |
| cause_kind | output | 2 | Last wake cause |
| cause_pin | output | 5 | Pin index of the last pin wake |

## Verification
All outputs are decoded from the state register. A request or pin change applied at one falling edge therefore shows at the next falling edge. The bench's acknowledge model lags the power enables by one register, which places SLEEP five cycles after the request and RUN four cycles after a pin wake. The bench samples at those exact falling edges. The timer result counts slow ticks while in SLEEP and has no fixed latency, so the bench checks it by a tick count against reload plus one rather than by a cycle number.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_GATE, ST_ISO, ST_PDN, ST_SLP, ST_PUP, ST_UISO
  } lpm_st_e;

  typedef enum logic [1:0] {
    CAUSE_RST = 2'd0,
    CAUSE_PIN = 2'd1,
    CAUSE_TMR = 2'd2
  } lpm_cause_e;
endpackage

// File: rtl/lpm_wake.sv
module lpm_wake #(
  parameter int NPIN = 32,
  parameter int TW   = 16,
  localparam int PW  = $clog2(NPIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pins,
  input  logic [NPIN-1:0] mask,
  input  logic            tick,
  input  logic [TW-1:0]   reload,
  input  logic            tmr_on,
  input  logic            slp_active,
  output logic            pin_hit,
  output logic [PW-1:0]   first_pin,
  output logic            tmr_fire
);
  logic [NPIN-1:0] hit;
  logic [TW-1:0]   cnt_q, cnt_d;

  assign hit     = pins & mask;
  assign pin_hit = |hit;

  always_comb begin
    first_pin = '0;
    for (int i = NPIN - 1; i >= 0; i--) begin
      if (hit[i]) first_pin = PW'(i);
    end
  end

  always_comb begin
    cnt_d    = cnt_q;
    tmr_fire = 1'b0;
    if (!slp_active) begin
      cnt_d = reload;
    end else if (tick) begin
      if (cnt_q == '0) tmr_fire = tmr_on;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9
  first_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_hit |-> (pins[first_pin] && mask[first_pin]));

  // R6
  tmr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slp_active && tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int NPIN     = 32,
  parameter int NBANK    = 3,
  parameter int NOSC     = 4,
  parameter int SLOW_OSC = 2,
  localparam int LW      = $clog2(NBANK + 1),
  localparam int PW      = $clog2(NPIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic [LW-1:0]    ret_lvl,
  input  logic [NOSC-1:0]  osc_keep,
  input  logic             tmr_en,
  input  logic             clk_release,
  input  logic             pin_hit,
  input  logic [PW-1:0]    first_pin,
  input  logic             tmr_fire,
  input  logic             pwr_ack,
  input  logic [NBANK-1:0] ram_ack,
  output logic             tmr_on,
  output logic             slp_active,
  output logic             clk_en,
  output logic             iso_en,
  output logic             pwr_en,
  output logic [NBANK-1:0] ram_pwr,
  output logic             dom_rst,
  output logic [NOSC-1:0]  osc_en,
  output logic             irc_sel,
  output logic             run_mode,
  output logic [1:0]       cause_kind,
  output logic [PW-1:0]    cause_pin
);
  lpm_st_e          st_q, st_d;
  logic [NBANK-1:0] ret_q, ret_map;
  logic [NOSC-1:0]  keep_q;
  logic             ten_q;
  logic             accept, wake_now, off_phase;
  lpm_cause_e       cause_q, cause_d;
  logic [PW-1:0]    cpin_q, cpin_d;
  logic             irc_q, irc_d;

  always_comb begin
    int lvl;
    lvl = int'(ret_lvl);
    if (lvl < 1)     lvl = 1;
    if (lvl > NBANK) lvl = NBANK;
    ret_map = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (b < lvl) ret_map[b] = 1'b1;
    end
  end

  assign accept = (st_q == ST_RUN) && sleep_req;

  always_comb begin
    st_d     = st_q;
    wake_now = 1'b0;
    unique case (st_q)
      ST_RUN:  if (sleep_req) st_d = ST_GATE;
      ST_GATE: begin st_d = pin_hit ? ST_RUN : ST_ISO; wake_now = pin_hit; end
      ST_ISO:  begin st_d = pin_hit ? ST_RUN : ST_PDN; wake_now = pin_hit; end
      ST_PDN: begin
        if (pin_hit) begin
          st_d = ST_PUP; wake_now = 1'b1;
        end else if (!pwr_ack && ram_ack == ret_q) begin
          st_d = ST_SLP;
        end
      end
      ST_SLP: if (pin_hit || tmr_fire) begin st_d = ST_PUP; wake_now = 1'b1; end
      ST_PUP:  if (pwr_ack && (&ram_ack)) st_d = ST_UISO;
      ST_UISO: st_d = ST_RUN;
      default: st_d = ST_RUN;
    endcase
  end

  always_comb begin
    cause_d = cause_q;
    cpin_d  = cpin_q;
    if (wake_now) begin
      cause_d = pin_hit ? CAUSE_PIN : CAUSE_TMR;
      cpin_d  = pin_hit ? first_pin : '0;
    end
    irc_d = irc_q;
    if (st_q == ST_PUP)                      irc_d = 1'b1;
    else if (st_q == ST_RUN && clk_release)  irc_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RUN;
      ret_q   <= '1;
      keep_q  <= '1;
      ten_q   <= 1'b0;
      cause_q <= CAUSE_RST;
      cpin_q  <= '0;
      irc_q   <= 1'b1;
    end else begin
      st_q    <= st_d;
      cause_q <= cause_d;
      cpin_q  <= cpin_d;
      irc_q   <= irc_d;
      if (accept) begin
        ret_q  <= ret_map;
        keep_q <= osc_keep;
        ten_q  <= tmr_en;
      end
    end
  end

  assign off_phase  = (st_q == ST_PDN) || (st_q == ST_SLP);
  assign slp_active = (st_q == ST_SLP);
  assign tmr_on     = ten_q;
  assign run_mode   = (st_q == ST_RUN);
  assign clk_en     = (st_q == ST_RUN) || (st_q == ST_UISO);
  assign iso_en     = (st_q == ST_ISO) || off_phase || (st_q == ST_PUP);
  assign pwr_en     = !off_phase;
  assign ram_pwr    = off_phase ? ret_q : '1;
  assign dom_rst    = (st_q == ST_PUP) || (st_q == ST_UISO);
  assign irc_sel    = irc_q;
  assign cause_kind = cause_q;
  assign cause_pin  = cpin_q;

  always_comb begin
    osc_en = '1;
    if (off_phase) begin
      osc_en = keep_q;
      if (ten_q) osc_en[SLOW_OSC] = 1'b1;
    end
  end

  // R2
  iso_before_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> ($past(iso_en) && !clk_en));

  // R7
  rst_after_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dom_rst) |-> ($past(clk_en) && !iso_en));

  // R8
  abort_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_GATE || st_q == ST_ISO) && pin_hit) |=> (run_mode && pwr_en));

  // R3
  ret_thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_pwr[0] && (((ram_pwr + 1'b1) & ram_pwr) == '0));

  // R10
  irc_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dom_rst) |=> irc_sel);

  // R6
  tmr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slp_active && tmr_fire && !pin_hit) |=> (cause_kind == CAUSE_TMR && dom_rst));
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int NPIN     = 32,
  parameter int NBANK    = 3,
  parameter int NOSC     = 4,
  parameter int SLOW_OSC = 2,
  parameter int TW       = 16,
  localparam int LW      = $clog2(NBANK + 1),
  localparam int PW      = $clog2(NPIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic [LW-1:0]    ret_lvl,
  input  logic [NOSC-1:0]  osc_keep,
  input  logic             tmr_en,
  input  logic [TW-1:0]    tmr_reload,
  input  logic             tick_slow,
  input  logic [NPIN-1:0]  wake_pins,
  input  logic [NPIN-1:0]  wake_mask,
  input  logic             clk_release,
  input  logic             pwr_ack,
  input  logic [NBANK-1:0] ram_ack,
  output logic             clk_en,
  output logic             iso_en,
  output logic             pwr_en,
  output logic [NBANK-1:0] ram_pwr,
  output logic             dom_rst,
  output logic [NOSC-1:0]  osc_en,
  output logic             irc_sel,
  output logic             run_mode,
  output logic             sleep_mode,
  output logic [1:0]       cause_kind,
  output logic [PW-1:0]    cause_pin
);
  logic          rs_q1, rs_q2;
  logic          pin_hit, tmr_fire, tmr_on, slp_active;
  logic [PW-1:0] first_pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end

  lpm_wake #(.NPIN(NPIN), .TW(TW)) u_wake (
    .clk(clk), .rst_n(rs_q2), .pins(wake_pins), .mask(wake_mask),
    .tick(tick_slow), .reload(tmr_reload), .tmr_on(tmr_on),
    .slp_active(slp_active), .pin_hit(pin_hit), .first_pin(first_pin),
    .tmr_fire(tmr_fire)
  );

  lpm_seq #(.NPIN(NPIN), .NBANK(NBANK), .NOSC(NOSC), .SLOW_OSC(SLOW_OSC)) u_seq (
    .clk(clk), .rst_n(rs_q2), .sleep_req(sleep_req), .ret_lvl(ret_lvl),
    .osc_keep(osc_keep), .tmr_en(tmr_en), .clk_release(clk_release),
    .pin_hit(pin_hit), .first_pin(first_pin), .tmr_fire(tmr_fire),
    .pwr_ack(pwr_ack), .ram_ack(ram_ack), .tmr_on(tmr_on),
    .slp_active(slp_active), .clk_en(clk_en), .iso_en(iso_en),
    .pwr_en(pwr_en), .ram_pwr(ram_pwr), .dom_rst(dom_rst), .osc_en(osc_en),
    .irc_sel(irc_sel), .run_mode(run_mode), .cause_kind(cause_kind),
    .cause_pin(cause_pin)
  );

  assign sleep_mode = slp_active;
endmodule

// File: tb/lpm_ctrl_bench.sv
module lpm_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0;
  logic [1:0] ret_lvl = '0;
  logic [3:0] osc_keep = '0;
  logic tmr_en = 1'b0;
  logic [15:0] tmr_reload = '0;
  logic tick_slow = 1'b0;
  logic [31:0] wake_pins = '0;
  logic [31:0] wake_mask = '0;
  logic clk_release = 1'b0;
  logic pwr_ack, tick_gen = 1'b0;
  logic [2:0] ram_ack;
  logic clk_en, iso_en, pwr_en, dom_rst, irc_sel, run_mode, sleep_mode;
  logic [2:0] ram_pwr;
  logic [3:0] osc_en;
  logic [1:0] cause_kind;
  logic [4:0] cause_pin;

  int total = 0, bad = 0, tcnt = 0, ph = 0;
  logic tcnt_clr = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;

  lpm_ctrl u_lpm_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .ret_lvl(ret_lvl),
    .osc_keep(osc_keep), .tmr_en(tmr_en), .tmr_reload(tmr_reload),
    .tick_slow(tick_slow), .wake_pins(wake_pins), .wake_mask(wake_mask),
    .clk_release(clk_release), .pwr_ack(pwr_ack), .ram_ack(ram_ack),
    .clk_en(clk_en), .iso_en(iso_en), .pwr_en(pwr_en), .ram_pwr(ram_pwr),
    .dom_rst(dom_rst), .osc_en(osc_en), .irc_sel(irc_sel),
    .run_mode(run_mode), .sleep_mode(sleep_mode), .cause_kind(cause_kind),
    .cause_pin(cause_pin)
  );

  // power switch model: acknowledges follow the enables after one register
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin pwr_ack <= 1'b1; ram_ack <= 3'b111; end
    else begin pwr_ack <= pwr_en; ram_ack <= ram_pwr; end
  end

  always @(negedge clk) begin
    ph = (ph == 2) ? 0 : ph + 1;
    tick_slow = tick_gen && (ph == 0);
  end

  always @(posedge clk) begin
    if (tcnt_clr) tcnt <= 0;
    else if (sleep_mode && tick_slow) tcnt <= tcnt + 1;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic nstep;
    @(negedge clk);
  endtask

  // request sleep and follow the entry sequence to SLEEP
  task automatic enter(input logic [1:0] lvl, input logic [3:0] keep, input logic ten);
    int exp_ram;
    ret_lvl = lvl; osc_keep = keep; tmr_en = ten; sleep_req = 1'b1;
    nstep; sleep_req = 1'b0;
    chk(clk_en == 1'b0 && pwr_en == 1'b1, "R2 gate", clk_en, 0);
    nstep;
    chk(iso_en == 1'b1 && pwr_en == 1'b1, "R2 iso", iso_en, 1);
    nstep;
    chk(pwr_en == 1'b0, "R2 poweroff", pwr_en, 0);
    nstep;
    chk(sleep_mode == 1'b0, "R2 ackwait", sleep_mode, 0);
    nstep;
    chk(sleep_mode == 1'b1, "R2 sleep", sleep_mode, 1);
    exp_ram = (1 << ((lvl == 0) ? 1 : int'(lvl))) - 1;
    chk(ram_pwr == 3'(exp_ram), "R3 retain", ram_pwr, exp_ram);
    chk(osc_en == (keep | {1'b0, ten, 2'b00}), "R4 osc", osc_en, keep | {1'b0, ten, 2'b00});
  endtask

  // exit path after a wake event applied at the current falling edge
  task automatic exit_seq;
    nstep;
    chk(pwr_en && iso_en && dom_rst && !clk_en && ram_pwr == 3'b111, "R7 pup", {pwr_en, iso_en, dom_rst, clk_en}, 14);
    chk(osc_en == 4'b1111, "R4 run osc", osc_en, 15);
    nstep;
    nstep;
    chk(!iso_en && clk_en && dom_rst, "R7 uiso", {iso_en, clk_en, dom_rst}, 3);
    nstep;
    chk(run_mode && !dom_rst && irc_sel, "R7 run", {run_mode, dom_rst, irc_sel}, 5);
  endtask

  initial begin
    repeat (3) nstep;
    rst_n = 1'b1;
    repeat (4) nstep;
    chk(run_mode && clk_en && pwr_en && !iso_en && !dom_rst, "R1 run", {run_mode, clk_en, pwr_en, iso_en, dom_rst}, 28);
    chk(ram_pwr == 3'b111 && osc_en == 4'b1111, "R1 power", {ram_pwr, osc_en}, 127);
    chk(irc_sel == 1'b1 && cause_kind == 2'd0, "R1 cause", {irc_sel, cause_kind}, 4);

    clk_release = 1'b1; nstep; clk_release = 1'b0;
    chk(irc_sel == 1'b0, "R10 release", irc_sel, 0);

    // sweep of retention level and keep mask; each pass wakes on a single enabled pin
    for (int i = 0; i < 64; i++) begin
      wake_mask = 32'h1 << (i % 32);
      wake_pins = '0;
      enter(2'(i / 16), 4'(i % 16), 1'b0);
      wake_pins = 32'hFFFF_FFFF;
      exit_seq;
      wake_pins = '0;
      chk(cause_kind == 2'd1 && cause_pin == 5'(i % 32), "R9 pin", cause_pin, i % 32);
      chk(irc_sel == 1'b1, "R10 exit", irc_sel, 1);
      clk_release = 1'b1; nstep; clk_release = 1'b0;
    end

    // masked pin has no effect; lowest enabled index wins
    wake_mask = 32'h0010_0200;
    enter(2'd2, 4'h0, 1'b0);
    wake_pins = 32'h0000_0020;
    repeat (10) nstep;
    chk(sleep_mode == 1'b1, "R5 masked", sleep_mode, 1);
    wake_pins = 32'h0010_0220;
    exit_seq;
    wake_pins = '0;
    chk(cause_pin == 5'd9, "R9 lowest", cause_pin, 9);

    // timer wake for several reload values
    wake_mask = '0;
    tick_gen = 1'b1;
    foreach (tmr_reload_list[k]) begin
      tmr_reload = tmr_reload_list[k];
      tcnt_clr = 1'b1; nstep; tcnt_clr = 1'b0;
      enter(2'd3, 4'h1, 1'b1);
      for (int w = 0; w < 2000 && !run_mode; w++) nstep;
      nstep;
      chk(run_mode == 1'b1, "R6 woke", run_mode, 1);
      chk(tcnt == int'(tmr_reload) + 1, "R6 ticks", tcnt, int'(tmr_reload) + 1);
      chk(cause_kind == 2'd2, "R9 timer", cause_kind, 2);
    end
    tick_gen = 1'b0;

    // abort during clock gating step
    wake_mask = 32'h8000_0000;
    ret_lvl = 2'd1; osc_keep = 4'h0; tmr_en = 1'b0;
    sleep_req = 1'b1; wake_pins = 32'h8000_0000;
    nstep; sleep_req = 1'b0;
    chk(pwr_en == 1'b1, "R8 gate on", pwr_en, 1);
    nstep;
    chk(run_mode && pwr_en && clk_en, "R8 gate abort", {run_mode, pwr_en, clk_en}, 7);
    chk(cause_kind == 2'd1 && cause_pin == 5'd31, "R9 abort", cause_pin, 31);
    wake_pins = '0;
    nstep;

    // abort during isolation step
    sleep_req = 1'b1;
    nstep; sleep_req = 1'b0;
    nstep;
    wake_pins = 32'h8000_0000;
    chk(iso_en == 1'b1, "R8 iso", iso_en, 1);
    nstep;
    chk(run_mode && pwr_en && !iso_en, "R8 iso abort", {run_mode, pwr_en, iso_en}, 6);
    wake_pins = '0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [15:0] tmr_reload_list [4] = '{16'd0, 16'd1, 16'd5, 16'd37};

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule